// File: doc/BRIEF.md
# Alarm Interrupt and Frequency Output Controller

This block drives one shared, active-low output pin from a 32.768 kHz timebase clock. The pin either signals an alarm interrupt or carries a clock: the raw timebase, the timebase divided down to 4096 Hz, or the timebase divided down to 1 Hz. A two-bit frequency select picks the function. When any clock is selected, alarm interrupts are kept off the pin.

Two alarm-match strobes arrive from an external time comparator, each gated by its own enable bit. In level mode, an enabled match sets a sticky per-alarm flag, and the pin stays asserted until software clears every set flag. In pulsed mode, every enabled match drives a fixed-length low pulse that ends by itself, so the alarm fires again on each later match without being re-armed.

All clocks come from one free-running binary counter. A new frequency select is captured only when that counter wraps, which is the 1 Hz boundary. This keeps the pin free of glitches when the function changes.

Top module: `alarm_fout_ctrl`

## Requirements
- R1: During reset and directly after it, the pin is high (not asserted), all alarm flags are 0 and the pin is in alarm mode.
- R2: The select codes are: 2'b00 for the alarm interrupt, 2'b01 for the timebase clock itself (pin high while the clock is high), 2'b10 for the clock divided by 2^FAST_LOG2 (8, which gives 4096 Hz), and 2'b11 for the clock divided by 2^SLOW_LOG2 (32768, which gives 1 Hz). The divided clocks equal bit FAST_LOG2-1 and bit SLOW_LOG2-1 of a counter that starts at 0 after reset and counts up by one every clock. Each divided clock is therefore low for the first half of its period.
- R3: A change on the select input takes effect only at the clock edge where the divider counter wraps from all ones to zero. Until that edge the pin keeps its previous function.
- R4: In level mode (pulse_mode_i = 0), a match strobe on an enabled alarm i sets flag_o[i] on the same edge. While any flag is set and alarm mode is selected, the pin is low.
- R5: A high flag_clr_i[i] clears flag_o[i] on the next edge. The pin goes high again only when every flag is clear. A match and a clear on the same alarm in the same cycle leave the flag set.
- R6: A match strobe on a disabled alarm is ignored. It sets no flag and does not assert the pin.
- R7: In pulsed mode (pulse_mode_i = 1), every enabled match drives the pin low for exactly PULSE_CYCLES clocks (8192, which is 250 ms). The pin then releases without any clear, and the next match pulses it again.
- R8: With both alarms enabled, a match on either one asserts the pin. Each alarm sets only its own flag.
- R9: While a clock output is selected, alarm matches do not reach the pin and the pin shows only the clock. Flags are still set by enabled matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz timebase clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alarm_en_i | input | NUM_ALARMS | Enable for each alarm |
| alarm_match_i | input | NUM_ALARMS | Single-cycle match strobe for each alarm |
| flag_clr_i | input | NUM_ALARMS | Clear strobe for each alarm flag |
| pulse_mode_i | input | 1 | 1 selects pulsed interrupts, 0 selects level interrupts |
| fsel_i | input | 2 | Pin function select |
| fout_n_o | output | 1 | Shared pin, low means interrupt asserted |
| flag_o | output | NUM_ALARMS | Sticky per-alarm status flags |

## Verification
The alarm path is exercised with a single match on each alarm, matches on both alarms, a match together with a clear in the same cycle, a match on a disabled alarm, and repeated matches in pulsed mode. Together these separate sticky from self-ending assertion and show that each alarm owns its own flag. The clock path is sampled at every counter phase for each select code and checked against the counter phase predicted by the bench. A select written just after a wrap exposes any change that lands before the next boundary. A match arriving while the 1 Hz clock is high shows whether the alarm leaks onto the clock output.

// File: rtl/afc_pkg.sv
package afc_pkg;
   typedef enum logic [1:0] {
      FSEL_ALARM = 2'b00,
      FSEL_RAW   = 2'b01,
      FSEL_FAST  = 2'b10,
      FSEL_SLOW  = 2'b11
   } fsel_e;
endpackage

// File: rtl/afc_divider.sv
module afc_divider
   import afc_pkg::*;
#(
   parameter int FAST_LOG2 = 3,
   parameter int SLOW_LOG2 = 15
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  fsel_e sel_i,
   output fsel_e sel_q_o,
   output logic  wrap_o,
   output logic  fast_o,
   output logic  slow_o
);
   logic [SLOW_LOG2-1:0] cnt_q;

   // counter at all ones: the next edge is the slow-clock boundary
   assign wrap_o = &cnt_q;
   assign fast_o = cnt_q[FAST_LOG2-1];
   assign slow_o = cnt_q[SLOW_LOG2-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         sel_q_o <= FSEL_ALARM;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (wrap_o) begin
            sel_q_o <= sel_i;
         end
      end
   end
endmodule

// File: rtl/afc_alarm_core.sv
module afc_alarm_core #(
   parameter int NUM_ALARMS   = 2,
   parameter int PULSE_CYCLES = 8192
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NUM_ALARMS-1:0] en_i,
   input  logic [NUM_ALARMS-1:0] match_i,
   input  logic [NUM_ALARMS-1:0] clr_i,
   input  logic                  pulse_mode_i,
   output logic [NUM_ALARMS-1:0] flag_o,
   output logic                  irq_o
);
   localparam int PW = $clog2(PULSE_CYCLES + 1);
   localparam logic [PW-1:0] PLOAD = PW'(PULSE_CYCLES);

   logic [NUM_ALARMS-1:0] hit;
   logic [PW-1:0]         pcnt_q;

   assign hit = match_i & en_i;

   for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            flag_o[i] <= 1'b0;
         end else if (hit[i]) begin
            flag_o[i] <= 1'b1;
         end else if (clr_i[i]) begin
            flag_o[i] <= 1'b0;
         end
      end
   end

   // a new hit reloads the pulse timer; otherwise it runs down to zero
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pcnt_q <= '0;
      end else if (pulse_mode_i && (|hit)) begin
         pcnt_q <= PLOAD;
      end else if (pcnt_q != '0) begin
         pcnt_q <= pcnt_q - 1'b1;
      end
   end

   assign irq_o = pulse_mode_i ? (pcnt_q != '0) : (|flag_o);
endmodule

// File: rtl/afc_pin_mux.sv
module afc_pin_mux
   import afc_pkg::*;
(
   input  logic  clk_i,
   input  fsel_e sel_i,
   input  logic  irq_i,
   input  logic  fast_i,
   input  logic  slow_i,
   output logic  pin_n_o
);
   always_comb begin
      case (sel_i)
         FSEL_ALARM: pin_n_o = ~irq_i;
         FSEL_RAW:   pin_n_o = clk_i;
         FSEL_FAST:  pin_n_o = fast_i;
         FSEL_SLOW:  pin_n_o = slow_i;
         default:    pin_n_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/alarm_fout_ctrl.sv
module alarm_fout_ctrl
   import afc_pkg::*;
#(
   parameter int NUM_ALARMS   = 2,
   parameter int FAST_LOG2    = 3,
   parameter int SLOW_LOG2    = 15,
   parameter int PULSE_CYCLES = 8192
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NUM_ALARMS-1:0] alarm_en_i,
   input  logic [NUM_ALARMS-1:0] alarm_match_i,
   input  logic [NUM_ALARMS-1:0] flag_clr_i,
   input  logic                  pulse_mode_i,
   input  logic [1:0]            fsel_i,
   output logic                  fout_n_o,
   output logic [NUM_ALARMS-1:0] flag_o
);
   if (NUM_ALARMS < 1) begin : g_bad_num
      $error("NUM_ALARMS must be at least 1");
   end
   if (FAST_LOG2 < 1 || FAST_LOG2 >= SLOW_LOG2) begin : g_bad_div
      $error("FAST_LOG2 must lie in 1 .. SLOW_LOG2-1");
   end
   if (PULSE_CYCLES < 1) begin : g_bad_pulse
      $error("PULSE_CYCLES must be at least 1");
   end

   fsel_e sel_q;
   logic  wrap;
   logic  fast_clk;
   logic  slow_clk;
   logic  irq;

   afc_divider #(
      .FAST_LOG2(FAST_LOG2),
      .SLOW_LOG2(SLOW_LOG2)
   ) i_divider (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (fsel_e'(fsel_i)),
      .sel_q_o(sel_q),
      .wrap_o (wrap),
      .fast_o (fast_clk),
      .slow_o (slow_clk)
   );

   afc_alarm_core #(
      .NUM_ALARMS  (NUM_ALARMS),
      .PULSE_CYCLES(PULSE_CYCLES)
   ) i_alarm_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (alarm_en_i),
      .match_i     (alarm_match_i),
      .clr_i       (flag_clr_i),
      .pulse_mode_i(pulse_mode_i),
      .flag_o      (flag_o),
      .irq_o       (irq)
   );

   afc_pin_mux i_pin_mux (
      .clk_i  (clk_i),
      .sel_i  (sel_q),
      .irq_i  (irq),
      .fast_i (fast_clk),
      .slow_i (slow_clk),
      .pin_n_o(fout_n_o)
   );
endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
   parameter int NUM_ALARMS = 2
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic [NUM_ALARMS-1:0] alarm_en_i,
   input logic [NUM_ALARMS-1:0] alarm_match_i,
   input logic [NUM_ALARMS-1:0] flag_clr_i,
   input logic                  pulse_mode_i,
   input logic                  fout_n_o,
   input logic [NUM_ALARMS-1:0] flag_o,
   input logic [1:0]            sel_q,
   input logic                  wrap
);
   for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_chk
      assert_flag_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (alarm_en_i[i] && alarm_match_i[i]) |=> flag_o[i]);
      assert_flag_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (flag_clr_i[i] && !(alarm_en_i[i] && alarm_match_i[i])) |=> !flag_o[i]);
      assert_disabled_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!alarm_en_i[i] && alarm_match_i[i] && !flag_o[i]) |=> !flag_o[i]);
   end

   assert_sel_at_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wrap |=> $stable(sel_q));

   assert_level_holds_pin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_q == 2'b00 && !pulse_mode_i && (|flag_o)) |-> !fout_n_o);

   assert_match_asserts_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_q == 2'b00 && !wrap && (|(alarm_en_i & alarm_match_i))) |=> !fout_n_o);
endmodule

bind alarm_fout_ctrl afc_checker #(.NUM_ALARMS(NUM_ALARMS)) i_afc_checker (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .alarm_en_i   (alarm_en_i),
   .alarm_match_i(alarm_match_i),
   .flag_clr_i   (flag_clr_i),
   .pulse_mode_i (pulse_mode_i),
   .fout_n_o     (fout_n_o),
   .flag_o       (flag_o),
   .sel_q        (sel_q),
   .wrap         (wrap)
);

// File: tb/test_alarm_fout_ctrl.sv
module test_alarm_fout_ctrl;
   localparam int NA    = 2;
   localparam int FAST  = 3;
   localparam int SLOW  = 8;
   localparam int PULSE = 12;
   localparam int M     = 1 << SLOW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NA-1:0] en = '0;
   logic [NA-1:0] match = '0;
   logic [NA-1:0] clr = '0;
   logic          pm = 1'b0;
   logic [1:0]    fsel = 2'b00;
   logic          pin;
   logic [NA-1:0] flag;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   alarm_fout_ctrl #(
      .NUM_ALARMS(NA), .FAST_LOG2(FAST), .SLOW_LOG2(SLOW), .PULSE_CYCLES(PULSE)
   ) i_alarm_fout_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .alarm_en_i(en), .alarm_match_i(match),
      .flag_clr_i(clr), .pulse_mode_i(pm), .fsel_i(fsel),
      .fout_n_o(pin), .flag_o(flag)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic nedge();
      @(negedge clk);
   endtask

   task automatic fire(input logic [NA-1:0] m, input logic [NA-1:0] c);
      match = m; clr = c;
      nedge();
      match = '0; clr = '0;
   endtask

   task automatic clear_all();
      fire('0, '1);
      nedge();
   endtask

   task automatic goto_wrap();
      do nedge(); while ((cyc % M) != 0);
   endtask

   task automatic t_reset();
      #2;
      chk("R1 pin in reset", pin, 1);
      chk("R1 flags in reset", flag, 0);
      nedge(); rst_n = 1'b1;
      nedge();
      chk("R1 pin after reset", pin, 1);
      chk("R1 flags after reset", flag, 0);
   endtask

   task automatic t_level();
      pm = 1'b0; en = 2'b01;
      fire(2'b01, '0);
      chk("R4 flag0 set", flag, 1);
      chk("R4 pin low", pin, 0);
      repeat (5) nedge();
      chk("R4 flag sticky", flag, 1);
      chk("R4 pin held", pin, 0);
      fire('0, 2'b01);
      chk("R5 flag cleared", flag, 0);
      chk("R5 pin released", pin, 1);
      fire(2'b01, 2'b01);
      chk("R5 set beats clear", flag, 1);
      clear_all();
   endtask

   task automatic t_disabled();
      pm = 1'b0; en = 2'b10;
      fire(2'b01, '0);
      chk("R6 no flag", flag, 0);
      chk("R6 pin idle", pin, 1);
      nedge();
      chk("R6 pin still idle", pin, 1);
   endtask

   task automatic t_both();
      pm = 1'b0; en = 2'b11;
      fire(2'b10, '0);
      chk("R8 only flag1", flag, 2);
      chk("R8 pin low on alarm1", pin, 0);
      fire(2'b01, '0);
      chk("R8 both flags", flag, 3);
      fire('0, 2'b01);
      chk("R5 one flag left", flag, 2);
      chk("R5 pin held by remaining flag", pin, 0);
      fire('0, 2'b10);
      chk("R5 pin released", pin, 1);
   endtask

   task automatic t_pulse();
      int lows;
      pm = 1'b1; en = 2'b11;
      for (int rep = 0; rep < 2; rep++) begin
         fire(rep == 0 ? 2'b01 : 2'b10, '0);
         lows = 0;
         while (pin == 1'b0 && lows < PULSE + 4) begin
            lows++;
            nedge();
         end
         chk("R7 pulse length", lows, PULSE);
         chk("R7 pin self-released", pin, 1);
      end
      repeat (3) nedge();
      chk("R7 no further pulse", pin, 1);
      clear_all();
      pm = 1'b0;
   endtask

   task automatic t_sel_clocks();
      // fast clock
      fsel = 2'b10;
      goto_wrap();
      for (int k = 0; k < 20; k++) begin
         chk("R2 fast clock", pin, ((cyc % M) >> (FAST - 1)) & 1);
         nedge();
      end
      // slow clock over a full period
      fsel = 2'b11;
      goto_wrap();
      for (int k = 0; k < M; k++) begin
         chk("R2 slow clock", pin, ((cyc % M) >> (SLOW - 1)) & 1);
         nedge();
      end
      // raw timebase
      fsel = 2'b01;
      goto_wrap();
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #2;
         chk("R2 raw clock high", pin, 1);
         @(negedge clk); #2;
         chk("R2 raw clock low", pin, 0);
      end
      fsel = 2'b00;
      goto_wrap();
      chk("R2 back to alarm mode", pin, 1);
   endtask

   task automatic t_sel_delay();
      goto_wrap();
      nedge();
      fsel = 2'b11;
      repeat (3) nedge();
      chk("R3 select not yet active", pin, 1);
      goto_wrap();
      chk("R3 select active after wrap", pin, 0);
   endtask

   task automatic t_mask();
      // slow clock selected from t_sel_delay; move to its high half
      pm = 1'b0; en = 2'b01;
      while ((cyc % M) < (M / 2 + 4)) nedge();
      fire(2'b01, '0);
      chk("R9 flag still set", flag, 1);
      chk("R9 pin shows clock high", pin, 1);
      nedge();
      chk("R9 pin shows clock high later", pin, 1);
      clear_all();
      fsel = 2'b00;
      goto_wrap();
      chk("R9 alarm mode restored idle", pin, 1);
   endtask

   initial begin
      t_reset();
      t_level();
      t_disabled();
      t_both();
      t_pulse();
      t_sel_clocks();
      t_sel_delay();
      t_mask();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung, expected finished run");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule